// File: doc/BRIEF.md
# DDR SDRAM Refresh Command Sequencer

This block produces the command stream that refreshes a four-bank DDR SDRAM. A memory controller raises a one-cycle request while the sequencer is idle. If any row is open, the sequencer closes the open rows with a precharge and lets the row-precharge time pass. It then issues a configurable chain of AUTO REFRESH commands. Each refresh is followed by its own refresh-cycle wait. A final one-cycle completion pulse marks the first cycle in which the controller may issue an ACTIVE command. Between commands the bus carries NOP. CKE stays high, and the data strobes, data and mask lines stay undriven.

The block keeps a record of which banks hold an open row. The controller reports each row opening and each row closing as an event while the sequencer is idle. That record sets the kind of precharge. A single open bank is closed on its own by its bank address with A8 low. Two or more open banks are closed together with A8 high. When no bank is open, the precharge and its wait are skipped. The record is cleared once the sequence completes. Both wait times are given as picosecond parameters and converted to clock cycles by rounding up.

The state machine has six states. IDLE→PRE is taken on a request with at least one open bank. IDLE→AREF is taken on a request with no open bank. PRE→WAIT_RP is taken when the precharge wait is at least one cycle, and PRE→AREF is taken otherwise. WAIT_RP→AREF is taken when the wait counter reaches zero. AREF→WAIT_RFC is taken when the refresh wait is at least one cycle. WAIT_RFC→AREF is taken when the counter is zero and refreshes remain. WAIT_RFC→DONE is taken when the counter is zero and the chain is complete. DONE→IDLE is taken unconditionally.

Top module: `ddr_refresh_seq`

## Requirements
- R1: During and after reset the command bus (CS#, RAS#, CAS#, WE#) carries NOP = 0111. CKE is 1, the data output enable is 0, busy and done are 0, and the open-bank mask is 0.
- R2: The controller reports bank events only in an idle cycle with no request. An open event sets bit `open_bank_i` of the mask, visible one cycle later. A close event clears bit `close_bank_i`. If both events name the same bank, the open event wins. Events in any other cycle leave the mask unchanged.
- R3: A request taken with at least one open bank puts PRECHARGE = 0010 on the bus one cycle after the request. A8 is 1 and BA is 0 when two or more banks are open. A8 is 0 and BA is the open bank's index when exactly one bank is open.
- R4: A request taken with no bank open puts AUTO REFRESH = 0001 on the bus one cycle after the request, with no precharge.
- R5: The first AUTO REFRESH follows the PRECHARGE by exactly ceil(TRP_PS / CLK_PERIOD_PS) cycles.
- R6: NUM_REFRESH (at least one) AUTO REFRESH commands are issued. Each is separated from the next by exactly ceil(TRFC_PS / CLK_PERIOD_PS) cycles. A8 and BA are 0 on each refresh.
- R7: Every other cycle of the sequence carries NOP = 0111, with A8 and BA at 0.
- R8: `done_o` is high for exactly one cycle, ceil(TRFC_PS / CLK_PERIOD_PS) cycles after the last AUTO REFRESH. In the following cycle the mask is 0 and the block is idle.
- R9: `busy_o` is high from the cycle after the request through the done cycle. A request raised while busy has no effect on the sequence.
- R10: CKE is 1 and the data output enable is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Refresh request, sampled when idle |
| open_evt_i | input | 1 | A row was opened in bank `open_bank_i` |
| open_bank_i | input | 2 | Bank index for the open event |
| close_evt_i | input | 1 | Bank `close_bank_i` was closed |
| close_bank_i | input | 2 | Bank index for the close event |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| a8_o | output | 1 | Address bit 8: all-bank precharge select |
| ba_o | output | 2 | Bank address |
| cke_o | output | 1 | Clock enable |
| dq_oe_o | output | 1 | Output enable for DQ, DM and DQS |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bank_open_o | output | 4 | Open-bank mask |

## Verification
All outputs are registered. A request sampled at one edge therefore shows its first command after that same edge. The bench numbers the cycles that follow the request from 1. The precharge is due at cycle 1 and the first refresh at cycle 1 + RP, where RP is 0 when no bank is open. Refresh i is due at cycle 1 + RP + i·RFC, and done is due at cycle 1 + RP + N·RFC. The cleared mask and the low busy flag are due one cycle after done. Bank events appear in the mask one cycle after they are driven. The bench drives inputs at falling edges and compares every output at the following falling edges against a function of the cycle index and the bench's own copy of the mask.

// File: rtl/ddr_refresh_pkg.sv
package ddr_refresh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT_RP,
        ST_AREF,
        ST_WAIT_RFC,
        ST_DONE
    } rfsh_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_PRE  = 4'b0010;
    localparam logic [3:0] CMD_AREF = 4'b0001;

    function automatic int unsigned cycles_ceil(int unsigned t_ps, int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R5 / R6: the wait counter only ever steps down by one while unloaded
    p_timer_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rfsh_bank_track.sv
module rfsh_bank_track #(
    parameter int unsigned NUM_BANKS = 4,
    localparam int unsigned BA_W = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 clear_i,
    input  logic                 open_evt_i,
    input  logic [BA_W-1:0]      open_bank_i,
    input  logic                 close_evt_i,
    input  logic [BA_W-1:0]      close_bank_i,
    output logic [NUM_BANKS-1:0] mask_o
);
    logic [NUM_BANKS-1:0] mask_q, mask_d;

    always_comb begin
        mask_d = mask_q;
        if (clear_i) begin
            mask_d = '0;
        end else if (en_i) begin
            if (close_evt_i) mask_d[close_bank_i] = 1'b0;
            if (open_evt_i)  mask_d[open_bank_i]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    // R2: without enable or clear the record holds its value
    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clear_i) |=> $stable(mask_q));

endmodule

// File: rtl/ddr_refresh_seq.sv
module ddr_refresh_seq
    import ddr_refresh_pkg::*;
#(
    parameter int unsigned NUM_BANKS     = 4,
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned TRP_PS        = 20000,
    parameter int unsigned TRFC_PS       = 62000,
    parameter int unsigned NUM_REFRESH   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       open_evt_i,
    input  logic [1:0] open_bank_i,
    input  logic       close_evt_i,
    input  logic [1:0] close_bank_i,
    output logic       cs_n_o,
    output logic       ras_n_o,
    output logic       cas_n_o,
    output logic       we_n_o,
    output logic       a8_o,
    output logic [1:0] ba_o,
    output logic       cke_o,
    output logic       dq_oe_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [3:0] bank_open_o
);
    localparam int unsigned BA_W     = $clog2(NUM_BANKS);
    localparam int unsigned RP_CYC   = cycles_ceil(TRP_PS, CLK_PERIOD_PS);
    localparam int unsigned RFC_CYC  = cycles_ceil(TRFC_PS, CLK_PERIOD_PS);
    localparam int unsigned WAIT_RP  = RP_CYC - 1;
    localparam int unsigned WAIT_RFC = RFC_CYC - 1;
    localparam int unsigned CNT_W    = $clog2(RP_CYC + RFC_CYC + 1);
    localparam int unsigned REF_W    = $clog2(NUM_REFRESH + 1);
    localparam int unsigned LD_RP_I  = (WAIT_RP  > 0) ? WAIT_RP  - 1 : 0;
    localparam int unsigned LD_RFC_I = (WAIT_RFC > 0) ? WAIT_RFC - 1 : 0;
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(LD_RP_I);
    localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(LD_RFC_I);

    rfsh_state_e          state_q, state_d;
    logic                 tmr_load, tmr_zero;
    logic [CNT_W-1:0]     tmr_val;
    logic [REF_W-1:0]     ref_cnt_q;
    logic [REF_W:0]       refs_now;
    logic                 last_ref;
    logic [NUM_BANKS-1:0] mask;
    logic                 any_open, multi_open;
    logic [BA_W-1:0]      single_idx;
    logic [3:0]           cmd_q;
    logic                 a8_q, done_q, busy_q;
    logic [BA_W-1:0]      ba_q;

    rfsh_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    rfsh_bank_track #(.NUM_BANKS(NUM_BANKS)) track_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (state_q == ST_IDLE && !req_i),
        .clear_i      (state_q == ST_DONE),
        .open_evt_i   (open_evt_i),
        .open_bank_i  (open_bank_i[BA_W-1:0]),
        .close_evt_i  (close_evt_i),
        .close_bank_i (close_bank_i[BA_W-1:0]),
        .mask_o       (mask)
    );

    assign any_open   = |mask;
    assign multi_open = ($countones(mask) > 1);

    always_comb begin
        single_idx = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (mask[i]) single_idx = BA_W'(i);
        end
    end

    assign refs_now = {1'b0, ref_cnt_q} + ((state_q == ST_AREF) ? (REF_W+1)'(1) : '0);
    assign last_ref = (refs_now >= (REF_W+1)'(NUM_REFRESH));

    // next-state and timer load
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) state_d = any_open ? ST_PRE : ST_AREF;
            end
            ST_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RP;
                state_d  = (WAIT_RP > 0) ? ST_WAIT_RP : ST_AREF;
            end
            ST_WAIT_RP: begin
                if (tmr_zero) state_d = ST_AREF;
            end
            ST_AREF: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RFC;
                if (WAIT_RFC > 0) state_d = ST_WAIT_RFC;
                else              state_d = last_ref ? ST_DONE : ST_AREF;
            end
            ST_WAIT_RFC: begin
                if (tmr_zero) state_d = last_ref ? ST_DONE : ST_AREF;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and refresh counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ref_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)      ref_cnt_q <= '0;
            else if (state_q == ST_AREF) ref_cnt_q <= ref_cnt_q + 1'b1;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            a8_q   <= 1'b0;
            ba_q   <= '0;
            done_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            cmd_q  <= CMD_NOP;
            a8_q   <= 1'b0;
            ba_q   <= '0;
            done_q <= (state_d == ST_DONE);
            busy_q <= (state_d != ST_IDLE);
            unique case (state_d)
                ST_PRE: begin
                    cmd_q <= CMD_PRE;
                    a8_q  <= multi_open;
                    ba_q  <= multi_open ? '0 : single_idx;
                end
                ST_AREF: cmd_q <= CMD_AREF;
                ST_IDLE, ST_WAIT_RP, ST_WAIT_RFC, ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
    assign a8_o        = a8_q;
    assign ba_o        = 2'(ba_q);
    assign cke_o       = 1'b1;
    assign dq_oe_o     = 1'b0;
    assign busy_o      = busy_q;
    assign done_o      = done_q;
    assign bank_open_o = 4'(mask);

    // ---- spacing monitors for the assertions ----
    localparam int unsigned GAP_MAX = RP_CYC + RFC_CYC + 2;
    localparam int unsigned GAP_W   = $clog2(GAP_MAX + 1);
    logic [GAP_W-1:0] since_pre_q, since_ar_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre_q <= GAP_W'(GAP_MAX);
            since_ar_q  <= GAP_W'(GAP_MAX);
        end else begin
            if (cmd_q == CMD_PRE)                     since_pre_q <= GAP_W'(1);
            else if (since_pre_q != GAP_W'(GAP_MAX))  since_pre_q <= since_pre_q + 1'b1;
            if (cmd_q == CMD_AREF)                    since_ar_q  <= GAP_W'(1);
            else if (since_ar_q != GAP_W'(GAP_MAX))   since_ar_q  <= since_ar_q + 1'b1;
        end
    end

    p_pre_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_AREF) |-> (since_pre_q >= GAP_W'(RP_CYC)));

    p_rfc_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_AREF) |-> (since_ar_q >= GAP_W'(RFC_CYC)));

    p_done_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (since_ar_q == GAP_W'(RFC_CYC)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> (!done_q && !busy_q && mask == '0));

    p_all_bank_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE && $countones(mask) > 1) |-> a8_q);

    p_single_bank_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE && !a8_q) |-> (mask[ba_q] && $countones(mask) == 1));

    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RP && !tmr_zero) |=> (state_q == ST_WAIT_RP));

    p_busy_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (cmd_q == CMD_NOP));

endmodule

// File: tb/ddr_refresh_seq_tb_top.sv
module ddr_refresh_seq_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TCK_PS = 8000;
    localparam int TRP    = 20000;
    localparam int TRFC   = 62000;
    localparam int NREF   = 2;
    localparam int RP_C   = (TRP  + TCK_PS - 1) / TCK_PS;
    localparam int RFC_C  = (TRFC + TCK_PS - 1) / TCK_PS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic       open_evt_i = 1'b0, close_evt_i = 1'b0;
    logic [1:0] open_bank_i = '0, close_bank_i = '0;
    logic       cs_n_o, ras_n_o, cas_n_o, we_n_o, a8_o, cke_o, dq_oe_o, busy_o, done_o;
    logic [1:0] ba_o;
    logic [3:0] bank_open_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] model_mask = '0;

    always #4 clk = ~clk;

    ddr_refresh_seq #(
        .NUM_BANKS(4), .CLK_PERIOD_PS(TCK_PS), .TRP_PS(TRP),
        .TRFC_PS(TRFC), .NUM_REFRESH(NREF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .open_evt_i(open_evt_i), .open_bank_i(open_bank_i),
        .close_evt_i(close_evt_i), .close_bank_i(close_bank_i),
        .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
        .a8_o(a8_o), .ba_o(ba_o), .cke_o(cke_o), .dq_oe_o(dq_oe_o),
        .busy_o(busy_o), .done_o(done_o), .bank_open_o(bank_open_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // expected {cmd[3:0], a8, ba[1:0], done} at cycle j after the request
    function automatic logic [7:0] expect_at(int j, logic [3:0] m);
        int n;
        int base;
        logic [1:0] idx;
        n = $countones(m);
        base = (n > 0) ? RP_C : 0;
        idx = '0;
        for (int b = 0; b < 4; b++) if (m[b]) idx = 2'(b);
        if (n > 0 && j == 1) return {4'b0010, (n > 1), (n > 1) ? 2'b00 : idx, 1'b0};
        for (int i = 0; i < NREF; i++)
            if (j == base + 1 + i * RFC_C) return {4'b0001, 1'b0, 2'b00, 1'b0};
        if (j == base + 1 + NREF * RFC_C) return {4'b0111, 1'b0, 2'b00, 1'b1};
        return {4'b0111, 1'b0, 2'b00, 1'b0};
    endfunction

    function automatic string tag_for(int j, logic [3:0] m);
        logic [7:0] e;
        e = expect_at(j, m);
        if (e[7:4] == 4'b0010) return "R3";
        if (e[7:4] == 4'b0001) return ($countones(m) > 0) ? "R5/R6" : "R4/R6";
        if (e[0]) return "R8";
        return "R7";
    endfunction

    task automatic bank_evt(bit do_open, int ob, bit do_close, int cb);
        @(negedge clk);
        open_evt_i = do_open;  open_bank_i  = 2'(ob);
        close_evt_i = do_close; close_bank_i = 2'(cb);
        @(negedge clk);
        open_evt_i = 1'b0; close_evt_i = 1'b0;
        if (do_close) model_mask[cb] = 1'b0;
        if (do_open)  model_mask[ob] = 1'b1;
        chk("R2", "mask after event", int'(bank_open_o), int'(model_mask));
    endtask

    task automatic run_seq(int pulse_at, int evt_at);
        logic [3:0] m;
        int L;
        logic [7:0] obs;
        m = model_mask;
        L = (($countones(m) > 0) ? RP_C : 0) + 1 + NREF * RFC_C;
        @(negedge clk);
        req_i = 1'b1;
        for (int j = 1; j <= L + 1; j++) begin
            @(negedge clk);
            obs = {cs_n_o, ras_n_o, cas_n_o, we_n_o, a8_o, ba_o, done_o};
            if (j <= L) begin
                chk(tag_for(j, m), "bus", int'(obs), int'(expect_at(j, m)));
                chk("R9", "busy during sequence", int'(busy_o), 1);
            end
            chk("R10", "cke/oe", int'({cke_o, dq_oe_o}), 2);
            if (j == L) chk("R2", "mask unchanged while busy", int'(bank_open_o), int'(m));
            if (j == L + 1) begin
                model_mask = '0;
                chk("R8", "idle after done", int'({busy_o, done_o}), 0);
                chk("R8", "mask cleared", int'(bank_open_o), 0);
                chk("R9", "no restart", int'(obs[7:4]), 7);
            end
            req_i = (j == pulse_at);
            open_evt_i = (j == evt_at);
            close_evt_i = (j == evt_at);
            open_bank_i = 2'(j);
            close_bank_i = 2'(j + 1);
        end
        open_evt_i = 1'b0; close_evt_i = 1'b0; req_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk("R1", "bus in reset", int'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "bus after reset", int'({cs_n_o, ras_n_o, cas_n_o, we_n_o, a8_o, ba_o}), 8'h70 >> 1);
        chk("R1", "cke/oe after reset", int'({cke_o, dq_oe_o}), 2);
        chk("R1", "busy/done after reset", int'({busy_o, done_o}), 0);
        chk("R1", "mask after reset", int'(bank_open_o), 0);

        // R4: no bank open, straight to refresh
        run_seq(0, 0);

        // R3: single bank, each index
        for (int b = 0; b < 4; b++) begin
            bank_evt(1'b1, b, 1'b0, 0);
            run_seq(0, 0);
        end

        // R2: open then close leaves nothing open; same-bank both events -> open wins
        bank_evt(1'b1, 1, 1'b0, 0);
        bank_evt(1'b0, 0, 1'b1, 1);
        bank_evt(1'b1, 2, 1'b1, 2);
        bank_evt(1'b1, 3, 1'b0, 0);
        // R3: two banks -> all-bank precharge
        run_seq(0, 0);

        // R9 / R2: request and bank events during the sequence are ignored
        bank_evt(1'b1, 0, 1'b0, 0);
        bank_evt(1'b1, 1, 1'b0, 0);
        bank_evt(1'b1, 2, 1'b0, 0);
        bank_evt(1'b1, 3, 1'b0, 0);
        run_seq(5, 3);
        run_seq(4, 9);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int nev;
            int len;
            nev = int'($urandom_range(0, 4));
            for (int e = 0; e < nev; e++)
                bank_evt(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                         1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
            len = (($countones(model_mask) > 0) ? RP_C : 0) + 1 + NREF * RFC_C;
            run_seq(int'($urandom_range(2, len - 2)), int'($urandom_range(2, len - 2)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule